// File: doc/BRIEF.md
# Up/Down Timer with Buffered PWM Output

This block is a general-purpose 16-bit timer for a control-oriented chip. A single counter steps up or down by one each clock while running. Two channel registers sit beside it, called the period channel and the edge channel. Each channel either records the counter on a rising edge of its own input pin, or compares against the counter and raises a flag on equality. The five event flags drive the interrupt lines directly and stay set until software clears them.

In waveform mode the counter always counts up and clears after it reaches the period channel value. A waveform output stays high while the counter is below the edge channel value. With buffered update selected, software writes land in shadow copies. The values that govern the waveform are refreshed only at the clock edge where the counter clears, so a cycle already under way always finishes with the settings it started with. A write that lands on that same edge is taken into the new cycle.

The register port has no handshake and is not a stream. Every write is accepted in the cycle it is presented, and a read returns data combinationally from the addressed register. No back-pressure exists anywhere in the block. The capture pins are asynchronous and are synchronised inside the block.

Top module: `updn_pwm_timer`

## Requirements
- R1: After reset, every register reads zero, the waveform output is low and all interrupt lines are low. The register addresses are: 0 control, 1 period channel, 2 edge channel, 3 counter, 4 flags. A write to address 3 loads the counter.
- R2: When control bit 0 (run) is set, the counter adds one on each clock edge. When run is clear, the counter holds its value.
- R3: Outside waveform mode, control bit 1 (down) selects counting down. The direction is taken from the control register on every edge. Stepping down from 0 gives 0xFFFF and sets flag bit 4 (underflow).
- R4: Flags are bit 0 period-channel match, bit 1 edge-channel match, bit 2 period-channel capture, bit 3 edge-channel capture and bit 4 underflow. Each flag stays set until a 1 is written to its bit at address 4. A 0 written to a bit leaves that flag unchanged. The irq output mirrors the flags.
- R5: A channel in compare mode sets its match flag when the running counter equals its active value.
- R6: A channel in capture mode stores the counter value and sets its capture flag on a rising edge of its pin. Control bit 4 puts the period channel in capture mode and bit 5 does the same for the edge channel. Capture is inactive in waveform mode.
- R7: A falling pin edge does not capture. A pin edge on a channel in compare mode also does not capture.
- R8: In waveform mode (control bit 2), the counter steps 0, 1, … up to the period value and then returns to 0.
- R9: In waveform mode, the output is high while the counter is below the edge value and low otherwise.
- R10: An edge value of 0 holds the output low. An edge value at or above the period value holds the output high.
- R11: With control bit 3 (buffered) set in waveform mode, channel writes read back at once. They take effect only from the next counter clear.
- R12: With buffered update off, a channel write governs the counter and the output from the next clock.
- R13: In buffered mode, a channel write that lands on the clock edge where the counter clears governs the cycle that this edge starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cap_in | input | 2 | Capture pins, bit 0 period channel, bit 1 edge channel |
| pwm_out | output | 1 | Waveform output |
| irq | output | 5 | Interrupt lines, one per flag |

## Verification
The sharpest coincidence in this block is a software write to a shadowed channel on the same edge where the counter clears and the buffered values are copied over. The bench waits until it reads the counter at its period value, then issues the write so that it lands exactly on the clearing edge. It then checks that the first samples of the new cycle already follow the written edge value and not the old one. A second coincidence is the underflow and both compare matches firing on one edge. This is provoked by counting down through zero while both channels compare against zero, and the flag word must then show all three bits.

// File: rtl/utm_pkg.sv
package utm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_REGA = 3'd1;
  localparam logic [ADDR_W-1:0] A_REGB = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

  localparam int NCH   = 2;
  localparam int NFLAG = 5;
  localparam int F_UDF = 4;

  typedef struct packed {
    logic cap_b;
    logic cap_a;
    logic dbuf;
    logic pwm;
    logic down;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/utm_edge_sync.sv
module utm_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/utm_counter.sv
module utm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         down,
  input  logic         pwm,
  input  logic [W-1:0] period,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         udf
);
  assign wrap = run & pwm & ~ld & (cnt >= period);
  assign udf  = run & ~pwm & down & ~ld & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (ld)       cnt <= ld_val;
    else if (run) begin
      if (pwm)         cnt <= wrap ? '0 : cnt + W'(1);
      else if (down)   cnt <= cnt - W'(1);
      else             cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/utm_chan.sv
module utm_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         dbuf,
  input  logic         load,
  input  logic         cap_take,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n)        shadow <= '0;
    else if (cap_take) shadow <= cnt;
    else if (wr)       shadow <= wr_data;
  end

  // A write on the refresh edge is forwarded so the new cycle uses it.
  always_ff @(posedge clk) begin
    if (!rst_n)             active <= '0;
    else if (cap_take)      active <= cnt;
    else if (wr && !dbuf)   active <= wr_data;
    else if (load)          active <= wr ? wr_data : shadow;
  end
endmodule

// File: rtl/updn_pwm_timer.sv
module updn_pwm_timer
  import utm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [NCH-1:0]    cap_in,
  output logic              pwm_out,
  output logic [NFLAG-1:0]  irq
);
  ctrl_t                       ctrl_q;
  logic [CNT_W-1:0]            cnt_q;
  logic                        wrap, udf;
  logic [NCH-1:0]              rise, cap_mode, cap_take, match, wr_ch;
  logic [NCH-1:0][CNT_W-1:0]   shadow_v, act_v;
  logic [CNT_W-1:0]            act_a, act_b;
  logic [NFLAG-1:0]            flags_q, flag_set, flag_clr;
  logic                        wr_ctrl, wr_cnt, wr_flag, dbuf_eff;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_cnt   = wr_en && (wr_addr == A_CNT);
  assign wr_flag  = wr_en && (wr_addr == A_FLAG);
  assign dbuf_eff = ctrl_q.dbuf & ctrl_q.pwm;
  assign cap_mode = {ctrl_q.cap_b, ctrl_q.cap_a};

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  utm_edge_sync #(.N(NCH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cap_in),
    .rise (rise)
  );

  utm_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_q.run),
    .down  (ctrl_q.down),
    .pwm   (ctrl_q.pwm),
    .period(act_a),
    .ld    (wr_cnt),
    .ld_val(wr_data),
    .cnt   (cnt_q),
    .wrap  (wrap),
    .udf   (udf)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = A_REGA + ADDR_W'(gi);
    logic cap_en;
    assign cap_en       = cap_mode[gi] & ~ctrl_q.pwm;
    assign cap_take[gi] = cap_en & rise[gi];
    assign wr_ch[gi]    = wr_en && (wr_addr == MY_ADDR);
    assign match[gi]    = ctrl_q.run & ~cap_en & ~wr_cnt & (cnt_q == act_v[gi]);

    utm_chan #(.W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_ch[gi]),
      .wr_data (wr_data),
      .dbuf    (dbuf_eff),
      .load    (wrap),
      .cap_take(cap_take[gi]),
      .cnt     (cnt_q),
      .shadow  (shadow_v[gi]),
      .active  (act_v[gi])
    );
  end

  assign act_a = act_v[0];
  assign act_b = act_v[1];

  // Flags: setting wins over a clear in the same cycle.
  assign flag_set = {udf, cap_take, match};
  assign flag_clr = wr_flag ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq = flags_q;

  assign pwm_out = ctrl_q.pwm & (act_b != '0) & ((act_b >= act_a) | (cnt_q < act_b));

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_REGA:  rd_data = shadow_v[0];
      A_REGB:  rd_data = shadow_v[1];
      A_CNT:   rd_data = cnt_q;
      A_FLAG:  rd_data = {{(CNT_W-NFLAG){1'b0}}, flags_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/utm_checker.sv
module utm_checker
  import utm_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic [CTRL_W-1:0] ctrl,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      act_a,
  input logic [W-1:0]      act_b,
  input logic [NFLAG-1:0]  flags,
  input logic              wrap,
  input logic              pwm_out
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_addr == A_CNT);

  // R3
  a_r3_udf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[1] && !ctrl[2] && cnt == '0 && !cnt_wr) |=> (cnt == '1 && flags[F_UDF]));

  // R4
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_UDF] && !(wr_en && wr_addr == A_FLAG && wr_data[F_UDF])) |=> flags[F_UDF]);

  // R8
  a_r8_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[2] && cnt >= act_a && !cnt_wr) |=> (cnt == '0));

  // R10
  a_r10_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b == '0) |-> !pwm_out);

  // R11
  a_r11_dbuf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && ctrl[3] && !wrap) |=> ($stable(act_a) && $stable(act_b)));

  // R12
  a_r12_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_REGB && !(ctrl[2] && ctrl[3]) && !(ctrl[5] && !ctrl[2]))
      |=> (act_b == $past(wr_data)));
endmodule

bind updn_pwm_timer utm_checker #(.W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .ctrl   (ctrl_q),
  .cnt    (cnt_q),
  .act_a  (act_a),
  .act_b  (act_b),
  .flags  (flags_q),
  .wrap   (wrap),
  .pwm_out(pwm_out)
);

// File: tb/test_updn_pwm_timer.sv
module test_updn_pwm_timer;
  import utm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  cap_in;
  logic        pwm_out;
  logic [4:0]  irq;

  always #5 clk = ~clk;

  updn_pwm_timer i_updn_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 waveform pin, 2 irq lines
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    checks = 0;
  int    fails  = 0;

  // Monitor: pops expected items and compares them with the pins.
  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t       it;
      logic [15:0] got;
      it = sb.pop_front();
      case (it.kind)
        0:       got = rd_data;
        1:       got = {15'd0, pwm_out};
        default: got = {11'd0, irq};
      endcase
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic lcheck(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic expect_rd(logic [2:0] a, logic [15:0] exp, string tag);
    rd_addr = a;
    #1;
    push(0, exp, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_count(logic [15:0] v);
    rd_addr = A_CNT;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      #1;
      if (rd_data == v) return;
    end
    lcheck(1'b0, "wait_count", int'(rd_data), int'(v));
  endtask

  function automatic logic pwm_rule(int c, int duty, int per);
    if (duty == 0) return 1'b0;
    if (duty >= per) return 1'b1;
    return (c < duty);
  endfunction

  task automatic pwm_sample(int n, int duty, int per, string tag);
    rd_addr = A_CNT;
    repeat (n) begin
      int c;
      @(negedge clk);
      #1;
      c = int'(rd_data);
      lcheck(c <= per, {tag, " R8 count within period"}, c, per);
      push(1, {15'd0, pwm_rule(c, duty, per)}, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; cap_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(A_CTRL, 16'h0, "R1 ctrl");
    expect_rd(A_REGA, 16'h0, "R1 period reg");
    expect_rd(A_REGB, 16'h0, "R1 edge reg");
    expect_rd(A_CNT,  16'h0, "R1 counter");
    expect_rd(A_FLAG, 16'h0, "R1 flags");
    push(1, 16'h0, "R1 pwm low");
    push(2, 16'h0, "R1 irq low");

    // R2 up count and hold
    wr(A_CNT, 16'h0010);
    wr(A_CTRL, 16'h0001);
    idle(5);
    wr(A_CTRL, 16'h0000);
    expect_rd(A_CNT, 16'h0016, "R2 up count");
    idle(3);
    expect_rd(A_CNT, 16'h0016, "R2 hold when stopped");

    // R3 down through zero, with both compare channels at zero
    wr(A_CNT, 16'h0002);
    wr(A_CTRL, 16'h0003);
    idle(2);
    wr(A_CTRL, 16'h0000);
    expect_rd(A_CNT, 16'hFFFF, "R3 wrap to all ones");
    expect_rd(A_FLAG, 16'h0013, "R3 R5 underflow and matches");
    idle(2);
    push(2, 16'h0013, "R4 flags sticky");
    wr(A_FLAG, 16'h0002);
    push(2, 16'h0011, "R4 partial clear");
    wr(A_FLAG, 16'h001F);
    push(2, 16'h0000, "R4 full clear");

    // R3 direction taken each edge
    wr(A_CNT, 16'h0005);
    wr(A_CTRL, 16'h0003);
    idle(1);
    wr(A_CTRL, 16'h0001);
    idle(2);
    wr(A_CTRL, 16'h0000);
    expect_rd(A_CNT, 16'h0006, "R3 direction change");

    // R5 compare match
    wr(A_REGA, 16'h0020);
    wr(A_CNT, 16'h001E);
    wr(A_CTRL, 16'h0001);
    idle(3);
    wr(A_CTRL, 16'h0000);
    expect_rd(A_FLAG, 16'h0001, "R5 period channel match");
    expect_rd(A_CNT, 16'h0022, "R2 count after match run");
    wr(A_FLAG, 16'h001F);

    // R6 capture on rising edge
    wr(A_CTRL, 16'h0010);
    wr(A_CNT, 16'h1234);
    cap_in = 2'b01;
    idle(4);
    wr(A_CNT, 16'h5555);
    cap_in = 2'b00;
    idle(4);
    expect_rd(A_REGA, 16'h1234, "R6 R7 captured value, falling edge ignored");
    expect_rd(A_FLAG, 16'h0004, "R6 capture flag");
    cap_in = 2'b10;
    idle(4);
    cap_in = 2'b00;
    idle(4);
    expect_rd(A_REGB, 16'h0000, "R7 compare channel ignores pin");
    expect_rd(A_FLAG, 16'h0004, "R7 no edge channel capture flag");
    wr(A_FLAG, 16'h001F);

    // R8 R9 waveform, unbuffered
    wr(A_CTRL, 16'h0004);
    wr(A_CNT, 16'h0000);
    wr(A_REGA, 16'h0007);
    wr(A_REGB, 16'h0003);
    wr(A_CTRL, 16'h0005);
    pwm_sample(20, 3, 7, "R9 waveform");
    push(2, 16'h0003, "R8 match flags in waveform mode");
    wr(A_REGB, 16'h0000);
    pwm_sample(10, 0, 7, "R10 R12 zero edge low");
    wr(A_REGB, 16'h0007);
    pwm_sample(10, 7, 7, "R10 edge equals period high");
    wr(A_REGB, 16'h00C8);
    pwm_sample(10, 200, 7, "R10 edge above period high");

    // R11 buffered update mid-cycle
    wr(A_CTRL, 16'h0004);
    wr(A_CNT, 16'h0000);
    wr(A_REGA, 16'h0009);
    wr(A_REGB, 16'h0002);
    wr(A_CTRL, 16'h000D);
    wait_count(16'h0004);
    wr(A_REGB, 16'h0006);
    wr(A_REGA, 16'h0005);
    expect_rd(A_REGB, 16'h0006, "R11 edge readback");
    expect_rd(A_REGA, 16'h0005, "R11 period readback");
    begin
      bit sw = 1'b0;
      rd_addr = A_CNT;
      repeat (20) begin
        int c;
        @(negedge clk);
        #1;
        c = int'(rd_data);
        if (c == 0) sw = 1'b1;
        lcheck(c <= (sw ? 5 : 9), "R11 period follows boundary", c, sw ? 5 : 9);
        push(1, {15'd0, pwm_rule(c, sw ? 6 : 2, sw ? 5 : 9)}, "R11 buffered waveform");
      end
      lcheck(sw, "R11 boundary reached", int'(sw), 1);
    end

    // R13 write landing on the clearing edge
    wr(A_CTRL, 16'h0004);
    wr(A_REGA, 16'h0009);
    wr(A_REGB, 16'h0006);
    wr(A_CNT, 16'h0000);
    wr(A_CTRL, 16'h000D);
    wait_count(16'h0009);
    wr(A_REGB, 16'h0001);
    expect_rd(A_CNT, 16'h0000, "R13 write on clearing edge");
    push(1, 16'h0001, "R13 first sample high");
    pwm_sample(10, 1, 9, "R13 new edge in force");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule